// File: doc/BRIEF.md
# Multi-Word Control/Status Register Bank

This block is a small register bank sitting behind a plain word-wide register port: an address, a write enable, write data and registered read data. It holds three registers. A raw single-word register passes each bus write straight to the core as a data word with a one-cycle strobe, and reads back whatever the core presents. A wide storage register, wider than the bus word, is visible to the core as one vector. A wide status register returns a value driven by the core.

The two wide registers are cut into bus-word slices at consecutive addresses, with the most significant slice first. The storage register can be built in a direct variant, where every slice write lands at once. It can also be built in an atomic variant. There, all slices but the last are collected in a back buffer and the whole value is moved into the visible storage when the last slice is written. The core therefore never sees a half-written value.

The bank answers only when the upper address bits equal a parameterized base. Inside the bank, offset 0 is the raw register. The storage slices follow, and the status slices come after them.

Top module: `csr_word_bank`

## Requirements
- R1: An access whose upper address bits (above the local offset field) differ from BANK_BASE has no effect on any register or strobe, and the read data in the following cycle is zero.
- R2: Read data is registered: `bus_dat_r` shows, one cycle after an address is presented, the value of that location. It is zero for offsets past the last status slice. It is zero after reset.
- R3: A write to offset 0 raises `raw_stb` for exactly the next cycle, with `raw_q` holding the written word in that cycle.
- R4: A read of offset 0 returns the value on `raw_d` in the cycle the address was presented.
- R5: The storage register uses ceil(STORE_W/DW) offsets starting at 1. Offset 1 holds the most significant slice and the last storage offset holds bits DW-1..0.
- R6: After reset the storage register equals RESET_VAL and, in atomic mode, the back buffer is zero. A commit that only writes the last slice therefore clears all upper slices.
- R7: In direct mode (ATOMIC=0), a write to any storage slice updates that slice of `store_q` in the next cycle and pulses `store_stb` for that cycle.
- R8: In atomic mode (ATOMIC=1), writes to storage slices other than the last leave `store_q` unchanged and raise no strobe. A write to the last slice loads all slices at once into `store_q`, with `store_stb` high for the next cycle.
- R9: The most significant storage slice is zero-padded on read, and written bits above STORE_W are discarded.
- R10: Status slices follow the storage slices, most significant first. Each read returns the slice of `status_d` live in the cycle that slice's address was presented, so a wide read is not atomic.
- R11: The storage register reads back through the bus at all times. Back-to-back commits each produce their own strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_adr | input | ADDR_W | Register address, bank select in the upper bits |
| bus_we | input | 1 | Write enable for the current address |
| bus_dat_w | input | DW | Write data |
| bus_dat_r | output | DW | Registered read data |
| raw_q | output | DW | Last word written to the raw register |
| raw_stb | output | 1 | One-cycle strobe qualifying `raw_q` |
| raw_d | input | DW | Core value returned on raw reads |
| store_q | output | STORE_W | Full visible storage value |
| store_stb | output | 1 | One-cycle strobe on storage update |
| status_d | input | STATUS_W | Core value returned by status reads |

## Verification
The assertions take for granted that every port input carries a known value on each clock edge after reset, and that the write enable stays low while reset is held. They also assume the bus makes at most one access per cycle, which the single address port enforces. The stimulus changes all inputs together on the falling edge only, holds them for one full cycle, and changes `status_d` between the two slice reads of the status register so that the live, non-atomic read is visible. A behavioural model of both the atomic and direct variants is compared against the two instances on every clock.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_RAW    = 2'd1,
      SEL_STORE  = 2'd2,
      SEL_STATUS = 2'd3
   } csr_sel_e;

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec
   import csr_bank_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LOC_W  = 4,
   parameter logic [ADDR_W-LOC_W-1:0] BANK_BASE = '0,
   parameter int NS = 3,
   parameter int NT = 2,
   parameter int IW = 2
) (
   input  logic [ADDR_W-1:0] adr,
   output csr_sel_e          sel,
   output logic [IW-1:0]     idx
);
   localparam int STORE_LO  = 1;
   localparam int STATUS_LO = STORE_LO + NS;
   localparam int END_OFF   = STATUS_LO + NT;

   logic             bank_hit;
   logic [LOC_W-1:0] off;
   int               off_i;

   assign bank_hit = (adr[ADDR_W-1:LOC_W] == BANK_BASE);
   assign off      = adr[LOC_W-1:0];
   assign off_i    = int'(off);

   always_comb begin
      sel = SEL_NONE;
      idx = '0;
      if (bank_hit) begin
         if (off_i == 0) begin
            sel = SEL_RAW;
         end else if (off_i < STATUS_LO) begin
            sel = SEL_STORE;
            idx = IW'(off_i - STORE_LO);
         end else if (off_i < END_OFF) begin
            sel = SEL_STATUS;
            idx = IW'(off_i - STATUS_LO);
         end
      end
   end
endmodule

// File: rtl/csr_raw_reg.sv
module csr_raw_reg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] q,
   output logic          stb
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q   <= '0;
         stb <= 1'b0;
      end else begin
         stb <= wr;
         if (wr) q <= din;
      end
   end
endmodule

// File: rtl/csr_wide_store.sv
module csr_wide_store #(
   parameter int DW     = 8,
   parameter int W      = 20,
   parameter int NS     = 3,
   parameter int IW     = 2,
   parameter bit ATOMIC = 1'b1,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] din,
   output logic [W-1:0]  value,
   output logic          stb
);
   localparam int PW = NS * DW;

   logic [PW-1:0] cur_pad;
   logic [PW-1:0] next_pad;
   logic          load;

   assign cur_pad = PW'(value);

   generate
      if (ATOMIC && NS > 1) begin : g_atomic
         logic [DW-1:0] back [NS-1];
         logic          last_wr;

         assign last_wr = wr && (idx == IW'(NS - 1));

         for (genvar k = 0; k < NS - 1; k++) begin : g_back
            always_ff @(posedge clk) begin
               if (!rst_n)                          back[k] <= '0;
               else if (wr && (idx == IW'(k)))      back[k] <= din;
            end
         end

         always_comb begin
            next_pad = '0;
            for (int k = 0; k < NS - 1; k++)
               next_pad[(NS-1-k)*DW +: DW] = back[k];
            next_pad[DW-1:0] = din;
         end
         assign load = last_wr;
      end else begin : g_direct
         always_comb begin
            next_pad = cur_pad;
            for (int k = 0; k < NS; k++)
               if (idx == IW'(k)) next_pad[(NS-1-k)*DW +: DW] = din;
         end
         assign load = wr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= RESET_VAL;
         stb   <= 1'b0;
      end else begin
         stb <= load;
         if (load) value <= next_pad[W-1:0];
      end
   end
endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
   import csr_bank_pkg::*;
#(
   parameter int DW       = 8,
   parameter int STORE_W  = 20,
   parameter int STATUS_W = 12,
   parameter int NS       = 3,
   parameter int NT       = 2,
   parameter int IW       = 2
) (
   input  csr_sel_e            sel,
   input  logic [IW-1:0]       idx,
   input  logic [DW-1:0]       raw_d,
   input  logic [STORE_W-1:0]  store_v,
   input  logic [STATUS_W-1:0] status_v,
   output logic [DW-1:0]       rd
);
   localparam int SPW = NS * DW;
   localparam int TPW = NT * DW;

   logic [SPW-1:0] store_pad;
   logic [TPW-1:0] status_pad;

   assign store_pad  = SPW'(store_v);
   assign status_pad = TPW'(status_v);

   always_comb begin
      rd = '0;
      unique case (sel)
         SEL_RAW:    rd = raw_d;
         SEL_STORE:
            for (int k = 0; k < NS; k++)
               if (idx == IW'(k)) rd = store_pad[(NS-1-k)*DW +: DW];
         SEL_STATUS:
            for (int k = 0; k < NT; k++)
               if (idx == IW'(k)) rd = status_pad[(NT-1-k)*DW +: DW];
         default:    rd = '0;
      endcase
   end
endmodule

// File: rtl/csr_word_bank.sv
module csr_word_bank
   import csr_bank_pkg::*;
#(
   parameter int DW       = 8,
   parameter int ADDR_W   = 8,
   parameter int LOC_W    = 4,
   parameter logic [ADDR_W-LOC_W-1:0] BANK_BASE = 4'h5,
   parameter int STORE_W  = 20,
   parameter int STATUS_W = 12,
   parameter bit ATOMIC   = 1'b1,
   parameter logic [STORE_W-1:0] RESET_VAL = 20'hA5C3E
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_adr,
   input  logic                bus_we,
   input  logic [DW-1:0]       bus_dat_w,
   output logic [DW-1:0]       bus_dat_r,
   output logic [DW-1:0]       raw_q,
   output logic                raw_stb,
   input  logic [DW-1:0]       raw_d,
   output logic [STORE_W-1:0]  store_q,
   output logic                store_stb,
   input  logic [STATUS_W-1:0] status_d
);
   localparam int NS = ceil_div(STORE_W, DW);
   localparam int NT = ceil_div(STATUS_W, DW);
   localparam int IW = idx_bits((NS > NT) ? NS : NT);

   initial begin
      assert (1 + NS + NT <= (1 << LOC_W))
         else $error("register map does not fit the local offset field");
      assert (LOC_W < ADDR_W)
         else $error("no bank select bits left in the address");
   end

   csr_sel_e      sel;
   logic [IW-1:0] idx;
   logic [DW-1:0] rd_next;

   csr_addr_dec #(
      .ADDR_W(ADDR_W), .LOC_W(LOC_W), .BANK_BASE(BANK_BASE),
      .NS(NS), .NT(NT), .IW(IW)
   ) i_dec (
      .adr(bus_adr), .sel(sel), .idx(idx)
   );

   csr_raw_reg #(.DW(DW)) i_raw (
      .clk(clk), .rst_n(rst_n),
      .wr(bus_we && (sel == SEL_RAW)),
      .din(bus_dat_w), .q(raw_q), .stb(raw_stb)
   );

   csr_wide_store #(
      .DW(DW), .W(STORE_W), .NS(NS), .IW(IW),
      .ATOMIC(ATOMIC), .RESET_VAL(RESET_VAL)
   ) i_store (
      .clk(clk), .rst_n(rst_n),
      .wr(bus_we && (sel == SEL_STORE)),
      .idx(idx), .din(bus_dat_w),
      .value(store_q), .stb(store_stb)
   );

   csr_read_mux #(
      .DW(DW), .STORE_W(STORE_W), .STATUS_W(STATUS_W),
      .NS(NS), .NT(NT), .IW(IW)
   ) i_rmux (
      .sel(sel), .idx(idx), .raw_d(raw_d),
      .store_v(store_q), .status_v(status_d), .rd(rd_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) bus_dat_r <= '0;
      else        bus_dat_r <= rd_next;
   end
endmodule

// File: rtl/csr_word_bank_chk.sv
module csr_word_bank_chk #(
   parameter int DW       = 8,
   parameter int ADDR_W   = 8,
   parameter int LOC_W    = 4,
   parameter logic [ADDR_W-LOC_W-1:0] BANK_BASE = 4'h5,
   parameter int STORE_W  = 20,
   parameter int STATUS_W = 12,
   parameter bit ATOMIC   = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_adr,
   input logic                bus_we,
   input logic [DW-1:0]       bus_dat_w,
   input logic [DW-1:0]       bus_dat_r,
   input logic [DW-1:0]       raw_q,
   input logic                raw_stb,
   input logic [STORE_W-1:0]  store_q,
   input logic                store_stb,
   input logic [STATUS_W-1:0] status_d
);
   localparam int NS  = (STORE_W + DW - 1) / DW;
   localparam int NT  = (STATUS_W + DW - 1) / DW;
   localparam int TPW = NT * DW;

   logic          in_bank;
   int            off;
   logic          raw_wr;
   logic          part_wr;
   logic          st_rd;
   logic [DW-1:0] st_slice;
   logic [TPW-1:0] st_pad;

   assign in_bank = (bus_adr[ADDR_W-1:LOC_W] == BANK_BASE);
   assign off     = int'(bus_adr[LOC_W-1:0]);
   assign raw_wr  = in_bank && bus_we && (off == 0);
   assign part_wr = in_bank && bus_we && (off >= 1) && (off < NS);
   assign st_rd   = in_bank && (off > NS) && (off <= NS + NT);
   assign st_pad  = TPW'(status_d);

   always_comb begin
      st_slice = '0;
      for (int k = 0; k < NT; k++)
         if (off == NS + 1 + k) st_slice = st_pad[(NT-1-k)*DW +: DW];
   end

   AST_FOREIGN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !in_bank |=> (bus_dat_r == '0)); // R1

   AST_RAW_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      raw_wr |=> (raw_stb && raw_q == $past(bus_dat_w))); // R3

   AST_RAW_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_wr |=> !raw_stb); // R3

   AST_STORE_HOLDS_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !store_stb |-> $stable(store_q)); // R11

   AST_STATUS_LIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd |=> (bus_dat_r == $past(st_slice))); // R10

   generate
      if (ATOMIC && NS > 1) begin : g_atomic_chk
         AST_PARTIAL_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
            part_wr |=> (!store_stb && $stable(store_q))); // R8
      end
   endgenerate
endmodule

bind csr_word_bank csr_word_bank_chk #(
   .DW(DW), .ADDR_W(ADDR_W), .LOC_W(LOC_W), .BANK_BASE(BANK_BASE),
   .STORE_W(STORE_W), .STATUS_W(STATUS_W), .ATOMIC(ATOMIC)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_adr(bus_adr), .bus_we(bus_we),
   .bus_dat_w(bus_dat_w), .bus_dat_r(bus_dat_r), .raw_q(raw_q),
   .raw_stb(raw_stb), .store_q(store_q), .store_stb(store_stb),
   .status_d(status_d)
);

// File: tb/test_csr_word_bank.sv
module test_csr_word_bank;
   localparam logic [19:0] RST_V = 20'hA5C3E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_adr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_dat_w = '0;
   logic [7:0]  raw_d = '0;
   logic [11:0] status_d = '0;

   logic [7:0]  rd_a, rd_d, rq_a, rq_d;
   logic        rs_a, rs_d, ss_a, ss_d;
   logic [19:0] sq_a, sq_d;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   csr_word_bank #(.ATOMIC(1'b1)) i_csr_word_bank (
      .clk(clk), .rst_n(rst_n), .bus_adr(bus_adr), .bus_we(bus_we),
      .bus_dat_w(bus_dat_w), .bus_dat_r(rd_a), .raw_q(rq_a), .raw_stb(rs_a),
      .raw_d(raw_d), .store_q(sq_a), .store_stb(ss_a), .status_d(status_d)
   );

   csr_word_bank #(.ATOMIC(1'b0)) i_csr_word_bank_direct (
      .clk(clk), .rst_n(rst_n), .bus_adr(bus_adr), .bus_we(bus_we),
      .bus_dat_w(bus_dat_w), .bus_dat_r(rd_d), .raw_q(rq_d), .raw_stb(rs_d),
      .raw_d(raw_d), .store_q(sq_d), .store_stb(ss_d), .status_d(status_d)
   );

   // reference model state: index 0 atomic instance, index 1 direct instance
   logic [19:0] m_store [2];
   logic [7:0]  m_back  [3];
   logic [7:0]  e_rd    [2];
   logic        e_sstb  [2];
   logic [7:0]  e_rq;
   logic        e_rstb;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk(tag, "atomic read data", 32'(rd_a), 32'(e_rd[0]));
      chk(tag, "direct read data", 32'(rd_d), 32'(e_rd[1]));
      chk(tag, "atomic store_q", 32'(sq_a), 32'(m_store[0]));
      chk(tag, "direct store_q", 32'(sq_d), 32'(m_store[1]));
      chk(tag, "atomic store_stb", 32'(ss_a), 32'(e_sstb[0]));
      chk(tag, "direct store_stb", 32'(ss_d), 32'(e_sstb[1]));
      chk(tag, "raw_stb", 32'(rs_a), 32'(e_rstb));
      chk(tag, "raw_stb direct", 32'(rs_d), 32'(e_rstb));
      if (e_rstb) begin
         chk(tag, "raw_q", 32'(rq_a), 32'(e_rq));
         chk(tag, "raw_q direct", 32'(rq_d), 32'(e_rq));
      end
   endtask

   task automatic cyc(input logic [7:0] a, input logic w, input logic [7:0] d,
                      input logic [7:0] rawv, input logic [11:0] st,
                      input string tag);
      logic        hit;
      int          off;
      logic [23:0] pad;
      logic [15:0] stp;
      logic [23:0] cm;
      bus_adr   = a;
      bus_we    = w;
      bus_dat_w = d;
      raw_d     = rawv;
      status_d  = st;
      hit = (a[7:4] == 4'h5);
      off = int'(a[3:0]);
      stp = 16'(st);
      for (int i = 0; i < 2; i++) begin
         pad = 24'(m_store[i]);
         e_rd[i] = 8'h00;
         if (hit) begin
            if (off == 0) e_rd[i] = rawv;
            else if (off <= 3) e_rd[i] = pad[(3 - off) * 8 +: 8];
            else if (off <= 5) e_rd[i] = stp[(5 - off) * 8 +: 8];
         end
         e_sstb[i] = 1'b0;
      end
      e_rstb = hit && w && (off == 0);
      if (e_rstb) e_rq = d;
      if (hit && w && off >= 1 && off <= 3) begin
         // atomic instance
         if (off < 3) m_back[off - 1] = d;
         else begin
            cm = {m_back[0], m_back[1], d};
            m_store[0] = cm[19:0];
            e_sstb[0] = 1'b1;
         end
         // direct instance
         pad = 24'(m_store[1]);
         pad[(3 - off) * 8 +: 8] = d;
         m_store[1] = pad[19:0];
         e_sstb[1] = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      cycles++;
      compare_all(tag);
   endtask

   initial begin
      m_store[0] = RST_V;
      m_store[1] = RST_V;
      for (int k = 0; k < 3; k++) m_back[k] = 8'h00;
      e_rq = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state: R6 storage value, R2 read data zero, no strobes
      chk("R6 reset", "atomic store_q", 32'(sq_a), 32'(RST_V));
      chk("R6 reset", "direct store_q", 32'(sq_d), 32'(RST_V));
      chk("R2 reset", "read data", 32'(rd_a), 32'h0);
      chk("R3 reset", "raw_stb", 32'(rs_a), 32'h0);
      chk("R7 reset", "store_stb", 32'(ss_d), 32'h0);

      cyc(8'h51, 0, 8'h00, 8'h00, 12'h000, "R5 R9 top slice padded");
      cyc(8'h52, 0, 8'h00, 8'h00, 12'h000, "R5 middle slice");
      cyc(8'h53, 0, 8'h00, 8'h00, 12'h000, "R5 low slice");
      cyc(8'h50, 1, 8'h3C, 8'h77, 12'h000, "R3 raw write");
      cyc(8'h50, 0, 8'h00, 8'h99, 12'h000, "R4 raw read");
      cyc(8'h53, 1, 8'h44, 8'h00, 12'h000, "R6 R8 R7 last slice with zero back buffer");
      cyc(8'h51, 1, 8'hFF, 8'h00, 12'h000, "R8 R9 R7 partial top write");
      cyc(8'h52, 1, 8'h12, 8'h00, 12'h000, "R8 R7 partial middle write");
      cyc(8'h51, 0, 8'h00, 8'h00, 12'h000, "R8 no partial visibility");
      cyc(8'h53, 1, 8'h34, 8'h00, 12'h000, "R8 commit");
      cyc(8'h51, 0, 8'h00, 8'h00, 12'h000, "R11 R9 readback top");
      cyc(8'h52, 0, 8'h00, 8'h00, 12'h000, "R11 readback middle");
      cyc(8'h53, 0, 8'h00, 8'h00, 12'h000, "R11 readback low");
      cyc(8'h54, 0, 8'h00, 8'h00, 12'hABC, "R10 status upper");
      cyc(8'h55, 0, 8'h00, 8'h00, 12'h123, "R10 status lower live");
      cyc(8'h56, 0, 8'h00, 8'h00, 12'hFFF, "R2 unmapped offset");
      cyc(8'h5F, 1, 8'h5A, 8'h00, 12'hFFF, "R2 unmapped write");
      cyc(8'h60, 1, 8'hAA, 8'h11, 12'h000, "R1 foreign raw write");
      cyc(8'h63, 1, 8'hBB, 8'h11, 12'h000, "R1 foreign store write");
      cyc(8'h61, 0, 8'h00, 8'h11, 12'h000, "R1 foreign read");
      cyc(8'h51, 0, 8'h00, 8'h00, 12'h000, "R1 storage unchanged");
      cyc(8'h53, 1, 8'h56, 8'h00, 12'h000, "R11 first back-to-back commit");
      cyc(8'h53, 1, 8'h78, 8'h00, 12'h000, "R11 second back-to-back commit");
      cyc(8'h50, 1, 8'hC3, 8'h00, 12'h000, "R3 raw write again");
      cyc(8'h50, 1, 8'h5D, 8'h00, 12'h000, "R3 raw consecutive write");
      cyc(8'h00, 0, 8'h00, 8'h00, 12'h000, "R3 strobe drops");
      cyc(8'h00, 0, 8'h00, 8'h00, 12'h000, "R2 idle");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule